// File: doc/BRIEF.md
# PCI Target Configuration Read Sequencer

This block handles the target side of single-DWORD configuration reads aimed at an extended capability window on a 32-bit PCI bus. It watches the bus for a type-0 configuration read addressed to this function, and captures the DWORD address. It then shows that address to a local back-end and raises a region select once the register number lands inside the window. From then on it paces DEVSEL#, TRDY# and the read data from a local ready handshake.

The back-end sees two things from the sequencer: the select, which it uses as a chip select, and an active-low transfer strobe. The strobe follows each cycle in which the back-end drove its ready low. The back-end puts a DWORD on its data input while the strobe is low. TRDY# waits until ready has been low for two back-to-back cycles. Bus drive is expressed as output enables beside the data and the active-low controls, so a pad ring or a bus model can resolve the tri-states.

Top module: `cfgrd_seq`

## Requirements
- R1: During and right after reset all three output enables are low, TRDY# and DEVSEL# read 1, the transfer strobe reads 1 and the region select is 0.
- R2: A transaction starts only in a cycle with FRAME# = 0, IDSEL = 1, C/BE# = 4'b1010 and AD[1:0] = 2'b00. Any other combination leaves every output inactive.
- R3: From the cycle after the address phase, the local address output holds the full captured AD word, and it stays unchanged while the region select is high.
- R4: The region select rises two clocks after the address phase (the third cycle) exactly when AD[7:2] lies in REG_LO..REG_HI inclusive. On a miss the block returns to idle and never enables DEVSEL#.
- R5: DEVSEL# is enabled and driven low on the clock after the region select rises.
- R6: The transfer strobe is low in a cycle exactly when the local ready was low in the previous cycle, the region select was high then, and the data phase had not completed.
- R7: TRDY# goes low only in the cycle after two consecutive cycles of local ready low (a gap restarts the count). AD then carries the local data sampled in the last cycle before TRDY#.
- R8: AD output enable is high only while TRDY# is driven low, so AD is never driven in the turnaround cycle that follows the address phase.
- R9: While IRDY# is high and TRDY# is low, TRDY# stays low and the AD value holds.
- R10: After a cycle with IRDY# and TRDY# both low, the next cycle shows DEVSEL# = 1 and TRDY# = 1, still enabled. In that cycle the AD enable, the region select and the transfer strobe are all inactive.
- R11: One cycle after that, the DEVSEL# and TRDY# enables drop and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | FRAME# from the bus |
| idsel | input | 1 | Configuration select for this function |
| ad_in | input | 32 | AD lines as seen on the bus |
| cbe_n | input | 4 | C/BE# lines |
| irdy_n | input | 1 | IRDY# from the master |
| be_rdy_n | input | 1 | Local ready, low = data can follow next cycle |
| be_data | input | 32 | Local read DWORD |
| ad_out | output | 32 | Data driven onto AD |
| ad_oe | output | 1 | AD drive enable |
| trdy_n | output | 1 | TRDY# value |
| trdy_oe | output | 1 | TRDY# drive enable |
| devsel_n | output | 1 | DEVSEL# value |
| devsel_oe | output | 1 | DEVSEL# drive enable |
| be_addr | output | 32 | Captured configuration address for the back-end |
| region_hit | output | 1 | Capability window select |
| xfer_n | output | 1 | Local transfer strobe, active low |

## Verification
The address phase is cycle 1. The address output is due in cycle 2, the select in cycle 3 and DEVSEL# in cycle 4. The strobe trails ready by one cycle. TRDY# falls two cycles after a ready run starts (more cycles after a gap). The release states come one and two cycles after the completing cycle. The bench builds each transaction as a numbered cycle loop: it samples the outputs 1 ns after the rising edge that opens cycle k, then drives the inputs for cycle k, and it compares against those cycle numbers. Sweeps cover every register number, rejected commands and address types, ready start and gap positions, and master wait lengths.

// File: rtl/cfgrd_seq.sv
`timescale 1ns/1ps
module cfgrd_seq #(
  parameter int REG_LO = 16,
  parameter int REG_HI = 47,
  parameter logic [3:0] RD_CMD = 4'b1010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        idsel,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  input  logic        irdy_n,
  input  logic        be_rdy_n,
  input  logic [31:0] be_data,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        trdy_n,
  output logic        trdy_oe,
  output logic        devsel_n,
  output logic        devsel_oe,
  output logic [31:0] be_addr,
  output logic        region_hit,
  output logic        xfer_n
);
  localparam logic [5:0] LO6 = REG_LO[5:0];
  localparam logic [5:0] HI6 = REG_HI[5:0];

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_HIT, S_DATA, S_DONE} st_t;
  st_t st;

  logic [31:0] addr_q, dat_q;
  logic rdy_q, trdy_q, xfer_q;

  wire start  = !frame_n && idsel && (cbe_n == RD_CMD) && (ad_in[1:0] == 2'b00);
  wire in_rng = (addr_q[7:2] >= LO6) && (addr_q[7:2] <= HI6);
  wire rdy    = !be_rdy_n;
  wire done   = (st == S_DATA) && !irdy_n && trdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      dat_q  <= '0;
      rdy_q  <= 1'b0;
      trdy_q <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_ADDR;
          addr_q <= ad_in;
        end
        S_ADDR: st <= in_rng ? S_HIT : S_IDLE;
        S_HIT:  st <= S_DATA;
        S_DATA: if (done) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
      rdy_q  <= region_hit && rdy;
      xfer_q <= ((st == S_HIT) || ((st == S_DATA) && !done)) && rdy;
      trdy_q <= (st == S_DATA) && !done && (trdy_q || (rdy && rdy_q));
      if (xfer_q && !trdy_q) dat_q <= be_data;
    end
  end

  assign region_hit = (st == S_HIT) || (st == S_DATA);
  assign devsel_oe  = (st == S_DATA) || (st == S_DONE);
  assign devsel_n   = (st != S_DATA);
  assign trdy_oe    = devsel_oe;
  assign trdy_n     = !trdy_q;
  assign ad_oe      = trdy_q;
  assign ad_out     = dat_q;
  assign xfer_n     = !xfer_q;
  assign be_addr    = addr_q;
endmodule

// File: rtl/cfgrd_seq_chk.sv
`timescale 1ns/1ps
module cfgrd_seq_chk #(
  parameter int REG_LO = 16,
  parameter int REG_HI = 47
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ad_in,
  input logic [3:0]  cbe_n,
  input logic        irdy_n,
  input logic        be_rdy_n,
  input logic [31:0] ad_out,
  input logic        ad_oe,
  input logic        trdy_n,
  input logic        trdy_oe,
  input logic        devsel_n,
  input logic        devsel_oe,
  input logic [31:0] be_addr,
  input logic        region_hit,
  input logic        xfer_n
);
  // R2
  cmd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region_hit) |-> ($past(cbe_n, 2) == 4'b1010) && ($past(ad_in[1:0], 2) == 2'b00));
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_hit |-> $stable(be_addr));
  // R4
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_hit |-> (int'(be_addr[7:2]) >= REG_LO) && (int'(be_addr[7:2]) <= REG_HI));
  // R5
  devsel_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region_hit) |=> (devsel_oe && !devsel_n));
  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_n |-> $past(!be_rdy_n) && $past(region_hit));
  // R7
  trdy_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> $past(!be_rdy_n) && $past(!be_rdy_n, 2));
  // R8
  ad_no_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(region_hit) |-> !ad_oe && !$past(ad_oe));
  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));
  // R10
  complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n) |=> (devsel_n && trdy_n && devsel_oe && trdy_oe && !ad_oe && !region_hit && xfer_n));
  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (devsel_oe && devsel_n) |=> (!devsel_oe && !trdy_oe));
endmodule

bind cfgrd_seq cfgrd_seq_chk #(.REG_LO(REG_LO), .REG_HI(REG_HI)) chk_i (.*);

// File: tb/cfgrd_seq_tb_top.sv
`timescale 1ns/1ps
module cfgrd_seq_tb_top;
  localparam int LO = 16;
  localparam int HI = 47;

  logic clk = 1'b0;
  logic rst_n, frame_n, idsel, irdy_n, be_rdy_n;
  logic [31:0] ad_in, be_data;
  logic [3:0] cbe_n;
  logic [31:0] ad_out, be_addr;
  logic ad_oe, trdy_n, trdy_oe, devsel_n, devsel_oe, region_hit, xfer_n;

  int n_chk = 0;
  int n_bad = 0;
  int txn_id = 0;

  always #2 clk = ~clk;

  cfgrd_seq #(.REG_LO(LO), .REG_HI(HI)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .idsel(idsel), .ad_in(ad_in),
    .cbe_n(cbe_n), .irdy_n(irdy_n), .be_rdy_n(be_rdy_n), .be_data(be_data),
    .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe),
    .devsel_n(devsel_n), .devsel_oe(devsel_oe), .be_addr(be_addr),
    .region_hit(region_hit), .xfer_n(xfer_n));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s txn %0d: actual %h expected %h", req, what, txn_id, act, exp);
    end
  endtask

  task automatic idle_inputs();
    frame_n = 1'b1; idsel = 1'b0; ad_in = '0; cbe_n = 4'hF;
    irdy_n = 1'b1; be_rdy_n = 1'b1; be_data = '0;
  endtask

  function automatic logic [31:0] dval(input int k);
    return 32'hD000_0000 | (txn_id << 8) | k;
  endfunction

  task automatic txn(input logic [3:0] cmd, input logic [1:0] lb, input logic sel,
                     input int rn, input int r, input int g, input int w);
    bit acc, hit;
    int t, c, len;
    logic [31:0] addr;
    txn_id++;
    acc  = sel && (cmd == 4'b1010) && (lb == 2'b00);
    hit  = acc && (rn >= LO) && (rn <= HI);
    t    = (g == 0) ? r + 2 : r + g + 3;
    c    = t + w;
    len  = hit ? c + 3 : 6;
    addr = {txn_id[15:0], 8'h5A, rn[5:0], lb};
    for (int k = 1; k <= len; k++) begin
      bit rl, rprev, exp_hit, exp_doe, exp_tr;
      @(posedge clk); #1;
      rprev   = hit && (k - 1 >= r) && (k - 1 <= c) && !((k - 1 > r) && (k - 1 <= r + g));
      exp_hit = hit && k >= 3 && k <= c;
      exp_doe = hit && k >= 4 && k <= c + 1;
      exp_tr  = hit && k >= t && k <= c;
      chk("R4", "region_hit", {31'b0, region_hit}, {31'b0, exp_hit});
      chk(hit ? "R5" : "R2", "devsel_oe", {31'b0, devsel_oe}, {31'b0, exp_doe});
      chk(k == c + 1 ? "R10" : "R5", "devsel_n", {31'b0, devsel_n}, {31'b0, !(hit && k >= 4 && k <= c)});
      chk(k == c + 2 ? "R11" : "R10", "trdy_oe", {31'b0, trdy_oe}, {31'b0, exp_doe});
      chk("R7", "trdy_n", {31'b0, trdy_n}, {31'b0, !exp_tr});
      chk("R8", "ad_oe", {31'b0, ad_oe}, {31'b0, exp_tr});
      chk("R6", "xfer_n", {31'b0, xfer_n}, {31'b0, !(hit && k >= 4 && k <= c && rprev)});
      if (exp_tr) chk(k > t ? "R9" : "R7", "ad_out", ad_out, dval(t - 1));
      if (acc && k >= 2 && (k == 2 || k <= c) && (hit || k == 2))
        chk("R3", "be_addr", be_addr, addr);
      rl = hit && k >= r && k <= c && !((k > r) && (k <= r + g));
      frame_n  = !(k == 1);
      idsel    = (k == 1) ? sel : 1'b0;
      ad_in    = (k == 1) ? addr : 32'h0;
      cbe_n    = (k == 1) ? cmd : ((hit ? k <= c : k <= 3) ? 4'h0 : 4'hF);
      irdy_n   = hit ? !(k >= 2 && k <= c && !(k >= t && k < t + w)) : !(k >= 2 && k <= 3);
      be_rdy_n = !rl;
      be_data  = dval(k);
    end
    @(posedge clk); #1;
    idle_inputs();
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    chk("R1", "ad_oe", {31'b0, ad_oe}, 32'h0);
    chk("R1", "devsel_oe", {31'b0, devsel_oe}, 32'h0);
    chk("R1", "trdy_oe", {31'b0, trdy_oe}, 32'h0);
    chk("R1", "region_hit", {31'b0, region_hit}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "trdy_n", {31'b0, trdy_n}, 32'h1);
    chk("R1", "devsel_n", {31'b0, devsel_n}, 32'h1);
    chk("R1", "xfer_n", {31'b0, xfer_n}, 32'h1);

    // R4: every register number, fastest back-end
    for (int rn = 0; rn < 64; rn++) txn(4'b1010, 2'b00, 1'b1, rn, 3, 0, 0);
    // R2: wrong command, type-1 address bits, no IDSEL
    txn(4'b1011, 2'b00, 1'b1, 20, 3, 0, 0);
    txn(4'b0110, 2'b00, 1'b1, 20, 3, 0, 0);
    txn(4'b0010, 2'b00, 1'b1, 20, 3, 0, 0);
    txn(4'b1010, 2'b01, 1'b1, 20, 3, 0, 0);
    txn(4'b1010, 2'b10, 1'b1, 20, 3, 0, 0);
    txn(4'b1010, 2'b00, 1'b0, 20, 3, 0, 0);
    // R6 R7 R9: ready start, ready gap, master wait
    for (int r = 3; r <= 6; r++)
      for (int g = 0; g <= 2; g++)
        for (int w = 0; w <= 2; w++)
          txn(4'b1010, 2'b00, 1'b1, LO + r + g + w, r, g, w);
    // R10 R11 boundary registers, back-to-back
    txn(4'b1010, 2'b00, 1'b1, LO, 3, 0, 1);
    txn(4'b1010, 2'b00, 1'b1, HI, 4, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule